// File: doc/BRIEF.md
# Serial Data-Link Byte Transmitter with Zero Insertion

This block feeds the low-rate data-link positions of an outgoing framed stream. A host writes a byte into a holding register. The framer timing pulses `bit_req` once for each link position. On each pulse the block puts one bit on `tx_bit`, least significant bit first. When the eighth data bit of a byte has gone out, the block sets a transmit-empty flag. If the interrupt is enabled, it also drives an active-low interrupt to ask for the next byte. If the host does not write a new byte in time, the same byte is sent again.

An optional zero inserter keeps the link free of runs longer than five ones. After five consecutive transmitted ones it sends one extra zero. While that zero goes out, the byte shifter pauses, so a byte always ends after eight real data bits. The count of ones carries over from one byte to the next.

The control is a two-state machine. `S_DATA` sends the next data bit on each request. `S_STUFF` sends a single inserted zero on the next request. Transitions:
- `S_DATA` to `S_STUFF` when a data one completes a run of five while insertion is enabled.
- `S_STUFF` to `S_DATA` on the next request.
- Every other request leaves `S_DATA` unchanged.

Top module: `dlink_tx`

## Requirements
- R1: After reset `tx_bit` is 0, `empty` is 1, and the holding byte is 0x00, so requests send zeros until the host writes.
- R2: Each `bit_req` pulse updates `tx_bit` at that clock edge. The byte's bits go out least significant first. With no request, `tx_bit` holds its value.
- R3: `empty` becomes 1 at the clock edge that sends the eighth data bit of a byte.
- R4: `irq_n` is 0 exactly when `empty` is 1 and `irq_en` is 1. Otherwise it is 1.
- R5: If no byte is written before the next byte starts, the previous byte is sent again.
- R6: A write is captured in the holding register. It takes effect only at the next byte boundary and does not change the byte in progress.
- R7: With `stuff_en`=1, the request after five consecutive transmitted ones sends an inserted 0.
- R8: An inserted 0 does not advance the byte shifter. `empty` is set only after eight data bits have gone out.
- R9: The run of ones continues across byte boundaries and is reset by any transmitted zero. With `stuff_en`=0 nothing is inserted.
- R10: A `clr_empty` pulse clears `empty`, and so does a host write. If a byte completes in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding byte |
| wr_data | input | 8 | Host byte to send |
| clr_empty | input | 1 | Write-one-to-clear strobe for `empty` |
| stuff_en | input | 1 | Enables zero insertion |
| irq_en | input | 1 | Interrupt enable for transmit-empty |
| bit_req | input | 1 | One-cycle request for the next link bit |
| tx_bit | output | 1 | Serial link bit |
| empty | output | 1 | Transmit-empty status |
| irq_n | output | 1 | Active-low interrupt |

## Verification
`tx_bit` and `empty` both change at the same rising edge that accepts a `bit_req`. A write or clear strobe changes `empty` at the edge that accepts it. `irq_n` follows `empty` and `irq_en` with no added register, so it is valid in the same cycle as `empty`.

The bench drives every strobe for exactly one cycle, starting at a falling edge. It samples outputs at the falling edge that follows the accepting rising edge, so each result is read one half-cycle after the edge that is due to produce it. Streams are compared bit by bit, one sample per request. Requests are spaced so that `tx_bit` staying stable between them is also observed.

// File: rtl/dlk_pkg.sv
package dlk_pkg;
    typedef enum logic {
        S_DATA  = 1'b0,
        S_STUFF = 1'b1
    } dlk_state_e;
endpackage

// File: rtl/dlk_hold.sv
module dlk_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr_empty,
    input  logic         byte_done,
    output logic [W-1:0] hold_q,
    output logic         empty_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
        end else begin
            if (wr_en) hold_q <= wr_data;
            if (byte_done)               empty_q <= 1'b1;
            else if (wr_en || clr_empty) empty_q <= 1'b0;
        end
    end

    AST_EMPTY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> empty_q); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(hold_q)); // R6
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_empty && !byte_done) |=> !empty_q); // R10
endmodule

// File: rtl/dlk_shifter.sv
module dlk_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] hold_byte,
    output logic         data_bit,
    output logic         byte_done
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    logic [W-1:0]  sh_q;
    logic [IW-1:0] idx_q;

    always_comb begin
        data_bit  = (idx_q == '0) ? hold_byte[0] : sh_q[0];
        byte_done = adv && (idx_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (adv) begin
            sh_q  <= (idx_q == '0) ? (hold_byte >> 1) : (sh_q >> 1);
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    AST_PAUSE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx_q)); // R8
endmodule

// File: rtl/dlk_stuff_ctl.sv
module dlk_stuff_ctl
    import dlk_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_req,
    input  logic stuff_en,
    input  logic data_bit,
    output logic adv,
    output logic tx_bit
);
    localparam int OW = $clog2(RUN_LEN + 1);
    localparam logic [OW-1:0] RUN_MAX = OW'(RUN_LEN);
    localparam logic [OW-1:0] RUN_TRIG = OW'(RUN_LEN - 1);

    dlk_state_e    state_q, state_d;
    logic [OW-1:0] ones_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_DATA: begin
                if (bit_req && data_bit && stuff_en && (ones_q >= RUN_TRIG))
                    state_d = S_STUFF;
            end
            S_STUFF: begin
                if (bit_req) state_d = S_DATA;
            end
            default: state_d = S_DATA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_DATA;
        else        state_q <= state_d;
    end

    assign adv = bit_req && (state_q == S_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
            ones_q <= '0;
        end else if (bit_req) begin
            unique case (state_q)
                S_STUFF: begin
                    tx_bit <= 1'b0;
                    ones_q <= '0;
                end
                default: begin
                    tx_bit <= data_bit;
                    if (!data_bit)              ones_q <= '0;
                    else if (ones_q != RUN_MAX) ones_q <= ones_q + 1'b1;
                end
            endcase
        end
    end

    AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STUFF && bit_req) |=> !tx_bit); // R7
    AST_STUFF_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && state_q == S_DATA && data_bit && stuff_en && ones_q == RUN_TRIG)
        |=> (state_q == S_STUFF)); // R7
    AST_NO_STUFF_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA && !stuff_en) |=> (state_q == S_DATA)); // R9
endmodule

// File: rtl/dlink_tx.sv
module dlink_tx #(
    parameter int W       = 8,
    parameter int RUN_LEN = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr_empty,
    input  logic         stuff_en,
    input  logic         irq_en,
    input  logic         bit_req,
    output logic         tx_bit,
    output logic         empty,
    output logic         irq_n
);
    logic [W-1:0] hold_q;
    logic         adv, data_bit, byte_done;

    dlk_hold #(.W(W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clr_empty(clr_empty), .byte_done(byte_done),
        .hold_q(hold_q), .empty_q(empty)
    );

    dlk_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .adv(adv), .hold_byte(hold_q),
        .data_bit(data_bit), .byte_done(byte_done)
    );

    dlk_stuff_ctl #(.RUN_LEN(RUN_LEN)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bit_req(bit_req), .stuff_en(stuff_en),
        .data_bit(data_bit), .adv(adv), .tx_bit(tx_bit)
    );

    assign irq_n = ~(empty & irq_en);

    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_req |=> $stable(tx_bit)); // R2
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> bit_req); // R3
endmodule

// File: tb/dlink_tx_bench.sv
module dlink_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, clr_empty = 1'b0, stuff_en = 1'b0;
    logic       irq_en = 1'b0, bit_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_bit, empty, irq_n;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dlink_tx u_dlink_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .clr_empty(clr_empty), .stuff_en(stuff_en), .irq_en(irq_en),
        .bit_req(bit_req), .tx_bit(tx_bit), .empty(empty), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [7:0]  b;
        logic        st;
        logic [4:0]  n;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{8'hA5, 1'b1, 5'd8,  16'h00A5},  // R2 plain byte, LSB first
        '{8'hFF, 1'b0, 5'd16, 16'hFFFF},  // R5 R9 resend, no insertion
        '{8'hFF, 1'b1, 5'd16, 16'hF7DF},  // R7 R9 run carries across boundary
        '{8'h1F, 1'b1, 5'd16, 16'h3E1F},  // R7 R8 zero after five ones
        '{8'h3E, 1'b1, 5'd12, 16'h0C3E},  // R7 run in middle of byte
        '{8'h3E, 1'b0, 5'd12, 16'h0E3E}   // R9 insertion off
    };

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic req(output logic b);
        @(negedge clk) bit_req = 1'b1;
        @(negedge clk) bit_req = 1'b0;
        b = tx_bit;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic host_clear();
        @(negedge clk) clr_empty = 1'b1;
        @(negedge clk) clr_empty = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic b;
        logic [15:0] got;

        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 tx_bit", tx_bit, 0);
        check("R1 empty", empty, 1);
        check("R4 irq_n masked", irq_n, 1);
        got = '0;
        for (int i = 0; i < 8; i++) begin req(b); got[i] = b; end
        check("R1 zeros sent", got, 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            do_reset();
            stuff_en = VEC[v].st;
            host_write(VEC[v].b);
            got = '0;
            for (int i = 0; i < int'(VEC[v].n); i++) begin req(b); got[i] = b; end
            check($sformatf("R2/R7 vector %0d stream", v), got, VEC[v].exp);
        end

        // R3 R10 empty timing and write clearing
        do_reset();
        stuff_en = 1'b0;
        host_write(8'h5A);
        check("R10 write clears empty", empty, 0);
        for (int i = 0; i < 7; i++) req(b);
        check("R3 empty after 7 bits", empty, 0);
        req(b);
        check("R3 empty after 8 bits", empty, 1);
        // R4 interrupt
        irq_en = 1'b1;
        @(negedge clk);
        check("R4 irq_n asserted", irq_n, 0);
        irq_en = 1'b0;
        @(negedge clk);
        check("R4 irq_n masked off", irq_n, 1);
        irq_en = 1'b1;
        host_clear();
        check("R10 clear empty", empty, 0);
        check("R4 irq_n after clear", irq_n, 1);
        // R5 resend sets empty again
        got = '0;
        for (int i = 0; i < 8; i++) begin req(b); got[i] = b; end
        check("R5 resent byte", got, 16'h005A);
        check("R5 empty on resend", empty, 1);
        irq_en = 1'b0;

        // R6 write mid-byte does not disturb byte in progress
        do_reset();
        stuff_en = 1'b0;
        got = '0;
        for (int i = 0; i < 4; i++) begin req(b); got[i] = b; end
        host_write(8'hFF);
        for (int i = 4; i < 16; i++) begin req(b); got[i] = b; end
        check("R6 mid-byte write", got, 16'hFF00);

        // R8 inserted zero pauses shifter: empty after 9th request
        do_reset();
        stuff_en = 1'b1;
        host_write(8'hFF);
        for (int i = 0; i < 8; i++) req(b);
        check("R8 empty not yet after 8 requests", empty, 0);
        req(b);
        check("R8 empty after 8 data bits", empty, 1);

        // R10 set wins over clear in same cycle
        do_reset();
        stuff_en = 1'b0;
        host_write(8'h01);
        for (int i = 0; i < 7; i++) req(b);
        @(negedge clk) begin bit_req = 1'b1; clr_empty = 1'b1; end
        @(negedge clk) begin bit_req = 1'b0; clr_empty = 1'b0; end
        check("R10 set wins", empty, 1);
        // R2 stable without request
        repeat (3) @(negedge clk);
        check("R2 tx_bit held", tx_bit, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule